// File: doc/BRIEF.md
# Streaming 3x3 Local Binary Pattern Encoder

This block turns a raster stream of grayscale pixels into a stream of 8-bit local binary pattern codes, one code for each interior pixel of the frame. Two line stores hold the two previous rows. A 3x3 register window slides along the current row, so the centre pixel and all eight of its neighbours are present in the same cycle. Eight comparators each produce one bit, and the bits are packed into a code in a fixed rotational order.

The input side has a pixel bus with a per-pixel qualifier, a line-active flag and a frame-active flag. The line length is taken from the line-active flag, so any width up to the line store depth works. The row position is counted from line ends and cleared while the frame flag is low. A centre on the outer ring of the frame never gets a complete window, so the block emits a code only when the window is complete. Codes come out in raster order of their centres, together with a matching valid strobe. The block accepts a new pixel on every clock and has no back-pressure.

Top module: `lbp_stream`

## Requirements
- R1: Each code bit is 1 when its neighbour's intensity is greater than or equal to the centre intensity, and 0 when the neighbour is smaller. A flat region therefore gives 8'hFF.
- R2: Bit positions are fixed, starting from the centre's right-hand neighbour and moving counterclockwise: bit0 right, bit1 upper-right, bit2 above, bit3 upper-left, bit4 left, bit5 lower-left, bit6 below, bit7 lower-right.
- R3: Accepting the pixel at row r, column c with r>=2 and c>=2 yields exactly one code, centred on row r-1, column c-1. Codes leave in raster order of their centres.
- R4: `code_valid` rises exactly two clock cycles after the rising edge that accepts the pixel completing the window.
- R5: No code is produced for a centre on the first or last row, or on the first or last column. A frame of W x H pixels yields exactly (W-2)*(H-2) codes.
- R6: A pixel is accepted only when `pix_valid`, `line_valid` and `frame_valid` are all high. Pixel values driven at any other time do not change the codes.
- R7: The line width is set by how long `line_valid` stays high. Widths from 3 up to `LINE_DEPTH` produce correct codes, including a width equal to `LINE_DEPTH`.
- R8: After synchronous reset, `code_valid` is 0 and `code` is 8'h00.
- R9: When `frame_valid` is low, the row and column positions return to zero. The first two rows of the next frame produce no codes, whatever the previous frame left in the window.
- R10: `code` keeps its last value in every cycle where `code_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix | input | 8 | Grayscale pixel value |
| pix_valid | input | 1 | Pixel qualifier |
| line_valid | input | 1 | High while a line is being delivered |
| frame_valid | input | 1 | High while a frame is being delivered |
| code | output | 8 | Local binary pattern code |
| code_valid | output | 1 | Marks a new code on `code` |

## Verification
The bench builds the block with `LINE_DEPTH` set to 12. At that depth, a frame that fills every line store entry is only a few hundred cycles long. A full-depth frame and narrower frames (3, 5 and 7 pixels wide) then run side by side, which puts both the exact-fill boundary and the short-line case in reach. Small 3x3 frames isolate one neighbour at a time to pin down each bit position. Frames with gaps in the qualifiers, and with junk pixel values driven during those gaps, show that only accepted pixels reach the codes. Back-to-back frames expose any window state left over across a frame boundary.

// File: rtl/lbp_pkg.sv
package lbp_pkg;

    parameter int LBP_PIX_W = 8;
    localparam int LBP_NB   = 8;
    localparam int LBP_ROWS = 3;
    localparam int LBP_TAPS = LBP_ROWS - 1;

    typedef logic [LBP_PIX_W-1:0] pix_t;
    typedef logic [LBP_NB-1:0]    code_t;

    // Each row: index 2 = rightmost (newest) column, index 0 = leftmost.
    typedef struct packed {
        pix_t [2:0] top;
        pix_t [2:0] mid;
        pix_t [2:0] bot;
    } win3_t;

    // Neighbour-to-bit mapping, counterclockwise from the right.
    typedef enum logic [2:0] {
        NB_R  = 3'd0,
        NB_TR = 3'd1,
        NB_T  = 3'd2,
        NB_TL = 3'd3,
        NB_L  = 3'd4,
        NB_BL = 3'd5,
        NB_B  = 3'd6,
        NB_BR = 3'd7
    } nb_e;

    function automatic code_t lbp_code(input win3_t w);
        pix_t  nb [LBP_NB];
        code_t c;
        nb[int'(NB_R)]  = w.mid[2];
        nb[int'(NB_TR)] = w.top[2];
        nb[int'(NB_T)]  = w.top[1];
        nb[int'(NB_TL)] = w.top[0];
        nb[int'(NB_L)]  = w.mid[0];
        nb[int'(NB_BL)] = w.bot[0];
        nb[int'(NB_B)]  = w.bot[1];
        nb[int'(NB_BR)] = w.bot[2];
        for (int k = 0; k < LBP_NB; k++) begin
            c[k] = (nb[k] >= w.mid[1]);
        end
        return c;
    endfunction

endpackage

// File: rtl/lbp_pos_track.sv
module lbp_pos_track
    import lbp_pkg::*;
#(
    parameter int LINE_DEPTH = 640,
    parameter int COL_W      = $clog2(LINE_DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pix_valid,
    input  logic             line_valid,
    input  logic             frame_valid,
    output logic [COL_W-1:0] col,
    output logic             wr_en,
    output logic             centre_ok
);

    localparam logic [COL_W-1:0] COL_MAX = COL_W'(LINE_DEPTH);

    logic [COL_W-1:0] col_q;
    logic [1:0]       row_q;
    logic             lv_q;
    logic             accept;
    logic             line_end;

    assign accept   = pix_valid && line_valid && frame_valid;
    assign line_end = lv_q && !line_valid;

    always_ff @(posedge clk) begin
        if (rst || !frame_valid) begin
            col_q <= '0;
            row_q <= '0;
            lv_q  <= 1'b0;
        end else begin
            lv_q <= line_valid;
            if (line_end) begin
                col_q <= '0;
                if (col_q != '0 && row_q != 2'd2) begin
                    row_q <= row_q + 2'd1;
                end
            end else if (accept && col_q != COL_MAX) begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    assign col       = col_q;
    assign wr_en     = accept && (col_q < COL_MAX);
    assign centre_ok = wr_en && (row_q == 2'd2) && (col_q >= COL_W'(2));

    p_col_bound_r7: assert property (@(posedge clk) disable iff (rst)
        col_q <= COL_MAX);

    p_row_sat_r5: assert property (@(posedge clk) disable iff (rst)
        row_q <= 2'd2);

    p_frame_clear_r9: assert property (@(posedge clk) disable iff (rst)
        !frame_valid |=> (col_q == '0 && row_q == 2'd0));

endmodule

// File: rtl/lbp_line_store.sv
module lbp_line_store
    import lbp_pkg::*;
#(
    parameter int LINE_DEPTH = 640,
    parameter int COL_W      = $clog2(LINE_DEPTH + 1),
    parameter int ADDR_W     = (LINE_DEPTH > 1) ? $clog2(LINE_DEPTH) : 1
) (
    input  logic                  clk,
    input  logic                  wr_en,
    input  logic [COL_W-1:0]      col,
    input  pix_t                  pix,
    output pix_t [LBP_TAPS-1:0]   taps
);

    logic [ADDR_W-1:0] addr;
    logic              in_range;

    assign addr     = col[ADDR_W-1:0];
    assign in_range = (col < COL_W'(LINE_DEPTH));

    // taps[0] = previous row, taps[1] = row before that.
    for (genvar k = 0; k < LBP_TAPS; k++) begin : g_row
        pix_t mem [LINE_DEPTH];
        pix_t wdata;

        if (k == 0) begin : g_first
            assign wdata = pix;
        end else begin : g_chain
            assign wdata = taps[k-1];
        end

        assign taps[k] = in_range ? mem[addr] : '0;

        always_ff @(posedge clk) begin
            if (wr_en) begin
                mem[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/lbp_window.sv
module lbp_window
    import lbp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                shift_en,
    input  logic                fresh_in,
    input  pix_t                pix,
    input  pix_t [LBP_TAPS-1:0] taps,
    output code_t               code,
    output logic                code_valid
);

    win3_t win_q;
    logic  fresh_q;
    code_t code_q;
    logic  valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            win_q   <= '0;
            fresh_q <= 1'b0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            if (shift_en) begin
                win_q.top <= {taps[1], win_q.top[2:1]};
                win_q.mid <= {taps[0], win_q.mid[2:1]};
                win_q.bot <= {pix,     win_q.bot[2:1]};
            end
            fresh_q <= fresh_in;
            valid_q <= fresh_q;
            if (fresh_q) begin
                code_q <= lbp_code(win_q);
            end
        end
    end

    assign code       = code_q;
    assign code_valid = valid_q;

    p_hold_code_r10: assert property (@(posedge clk) disable iff (rst)
        !fresh_q |=> $stable(code_q));

endmodule

// File: rtl/lbp_stream.sv
module lbp_stream
    import lbp_pkg::*;
#(
    parameter int LINE_DEPTH = 640
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LBP_PIX_W-1:0] pix,
    input  logic                 pix_valid,
    input  logic                 line_valid,
    input  logic                 frame_valid,
    output logic [LBP_NB-1:0]    code,
    output logic                 code_valid
);

    localparam int COL_W = $clog2(LINE_DEPTH + 1);

    logic [COL_W-1:0]    col;
    logic                wr_en;
    logic                centre_ok;
    pix_t [LBP_TAPS-1:0] taps;

    lbp_pos_track #(.LINE_DEPTH(LINE_DEPTH), .COL_W(COL_W)) u_track (
        .clk         (clk),
        .rst         (rst),
        .pix_valid   (pix_valid),
        .line_valid  (line_valid),
        .frame_valid (frame_valid),
        .col         (col),
        .wr_en       (wr_en),
        .centre_ok   (centre_ok)
    );

    lbp_line_store #(.LINE_DEPTH(LINE_DEPTH), .COL_W(COL_W)) u_lines (
        .clk   (clk),
        .wr_en (wr_en),
        .col   (col),
        .pix   (pix),
        .taps  (taps)
    );

    lbp_window u_win (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (wr_en),
        .fresh_in   (centre_ok),
        .pix        (pix),
        .taps       (taps),
        .code       (code),
        .code_valid (code_valid)
    );

    p_latency_r4: assert property (@(posedge clk) disable iff (rst)
        centre_ok |=> ##1 code_valid);

    p_needs_window_r3: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(centre_ok, 2));

    p_edge_col_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && col < COL_W'(2)) |=> ##1 !code_valid);

    p_in_frame_r9: assert property (@(posedge clk) disable iff (rst)
        code_valid |-> $past(frame_valid, 2));

endmodule

// File: tb/lbp_stream_bench.sv
module lbp_stream_bench;

    localparam int DEPTH = 12;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] pix = '0;
    logic       pix_valid = 1'b0;
    logic       line_valid = 1'b0;
    logic       frame_valid = 1'b0;
    logic [7:0] code;
    logic       code_valid;

    lbp_stream #(.LINE_DEPTH(DEPTH)) u_lbp_stream (
        .clk         (clk),
        .rst         (rst),
        .pix         (pix),
        .pix_valid   (pix_valid),
        .line_valid  (line_valid),
        .frame_valid (frame_valid),
        .code        (code),
        .code_valid  (code_valid)
    );

    always #10 clk = ~clk;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    logic [7:0] img  [0:15][0:15];
    int         dcyc [0:15][0:15];
    logic [7:0] got_code [0:255];
    int         got_cyc  [0:255];
    int         got_n = 0;
    bit         mon_en = 0;
    logic [7:0] last_code = '0;
    int         hold_err = 0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (code_valid) begin
                if (got_n < 256) begin
                    got_code[got_n] = code;
                    got_cyc[got_n]  = cyc;
                end
                got_n++;
                last_code = code;
            end else if (code !== last_code) begin
                hold_err++;
            end
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] model_code(input int r, input int c);
        int dr [8] = '{0, -1, -1, -1, 0, 1, 1, 1};
        int dc [8] = '{1, 1, 0, -1, -1, -1, 0, 1};
        logic [7:0] v;
        for (int k = 0; k < 8; k++) begin
            v[k] = (img[r+dr[k]][c+dc[k]] >= img[r][c]);
        end
        return v;
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pix_valid = 1'b0;
            pix       = 8'h5A ^ 8'(i);
        end
    endtask

    // Streams img[0..h-1][0..w-1]; gap inserts junk cycles (R6) then checks R3/R4/R5.
    task automatic run_frame(input int w, input int h, input bit gap, input string tag);
        int n_exp, idx;
        got_n = 0;
        @(negedge clk);
        frame_valid = 1'b1;
        idle(2);
        for (int r = 0; r < h; r++) begin
            @(negedge clk);
            line_valid = 1'b1;
            pix_valid  = 1'b0;
            for (int c = 0; c < w; c++) begin
                if (gap && ((r + c) % 3 == 0)) begin
                    pix       = ~img[r][c];
                    pix_valid = 1'b0;
                    @(negedge clk);
                end
                pix       = img[r][c];
                pix_valid = 1'b1;
                dcyc[r][c] = cyc;
                @(negedge clk);
            end
            line_valid = 1'b0;
            pix_valid  = gap;
            pix        = 8'hFF;
            @(negedge clk);
            pix_valid  = 1'b0;
            @(negedge clk);
        end
        idle(1);
        frame_valid = 1'b0;
        idle(3);
        n_exp = (w - 2) * (h - 2);
        check(got_n == n_exp, "R5", {tag, " code count"}, got_n, n_exp);
        idx = 0;
        for (int r = 1; r < h - 1; r++) begin
            for (int c = 1; c < w - 1; c++) begin
                if (idx < got_n && idx < 256) begin
                    check(got_code[idx] == model_code(r, c), "R3",
                          {tag, " code value"}, got_code[idx], model_code(r, c));
                    check(got_cyc[idx] == dcyc[r+1][c+1] + 2, "R4",
                          {tag, " code timing"}, got_cyc[idx], dcyc[r+1][c+1] + 2);
                end
                idx++;
            end
        end
    endtask

    task automatic fill(input int w, input int h, input int mode, input int seed);
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 16; c++) begin
                if (mode == 0)
                    img[r][c] = 8'(((r * 29 + c * 13 + seed * 7) ^ (r * c * 5)));
                else
                    img[r][c] = 8'(((r + c + seed) % 3) * 40);
            end
        end
    endtask

    task automatic t_reset();
        check(code_valid == 1'b0, "R8", "valid after reset", code_valid, 0);
        check(code == 8'h00, "R8", "code after reset", code, 0);
    endtask

    task automatic t_bit_order();
        int dr [8] = '{0, -1, -1, -1, 0, 1, 1, 1};
        int dc [8] = '{1, 1, 0, -1, -1, -1, 0, 1};
        for (int k = 0; k < 8; k++) begin
            for (int r = 0; r < 3; r++)
                for (int c = 0; c < 3; c++)
                    img[r][c] = 8'd50;
            img[1][1] = 8'd100;
            img[1+dr[k]][1+dc[k]] = 8'd200;
            run_frame(3, 3, 0, "R2 single neighbour");
            check(got_code[0] == 8'(1 << k), "R2", "bit position", got_code[0], 1 << k);
        end
    endtask

    task automatic t_compare_rule();
        for (int r = 0; r < 4; r++)
            for (int c = 0; c < 4; c++)
                img[r][c] = 8'd77;
        run_frame(4, 4, 0, "R1 flat");
        check(got_code[0] == 8'hFF && got_code[3] == 8'hFF, "R1", "equal gives ones",
              got_code[0], 8'hFF);
        for (int r = 0; r < 3; r++)
            for (int c = 0; c < 3; c++)
                img[r][c] = 8'd99;
        img[1][1] = 8'd100;
        run_frame(3, 3, 0, "R1 peak");
        check(got_code[0] == 8'h00, "R1", "smaller gives zeros", got_code[0], 0);
    endtask

    task automatic t_full_width();
        fill(DEPTH, 6, 0, 1);
        run_frame(DEPTH, 6, 0, "R7 full depth");
    endtask

    task automatic t_narrow();
        fill(5, 4, 1, 2);
        run_frame(5, 4, 0, "R7 narrow ties");
        fill(7, 5, 0, 3);
        run_frame(7, 5, 0, "R7 mid width");
    endtask

    task automatic t_gaps();
        fill(9, 6, 0, 4);
        run_frame(9, 6, 1, "R6 gapped");
    endtask

    task automatic t_back_to_back();
        fill(6, 5, 0, 5);
        run_frame(6, 5, 0, "R9 first");
        fill(6, 5, 1, 6);
        run_frame(6, 5, 0, "R9 second");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL R4 watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        mon_en = 1;
        t_bit_order();
        t_compare_rule();
        t_full_width();
        t_narrow();
        t_gaps();
        t_back_to_back();
        check(hold_err == 0, "R10", "code held while idle", hold_err, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule